// File: doc/BRIEF.md
# Fetch-Stage Branch Predictor with Return Stack

This block sits beside instruction fetch and guesses, one cycle after a fetch address is presented, whether that address holds a branch, whether it will be taken and where it will go. The guess comes from a set-associative target buffer. Each entry keeps a tag, a target, a flag marking it as a return, and a two-bit saturating direction counter. Entries marked as returns take their target from a small circular stack of return addresses instead of from the buffer.

Branch resolution later in the pipe sends one update per cycle. The update trains the direction counter and refreshes the target of an entry that is already present. It allocates a new entry for a taken branch that missed. A call pushes its sequential address onto the stack and a return pops it. A flush empties the buffer and the stack in a single cycle.

The lookup side is a stream with no back-pressure. The block accepts every `lk_valid` beat, and each beat produces exactly one `pred_valid` beat on the next cycle. The consumer must take that beat; it cannot stall the block. The update and flush pins are plain control.

Top module: `fetch_predictor`

## Requirements
- R1: A lookup presented with `lk_valid=1` at a clock edge yields `pred_valid=1` on the following cycle, with results taken from the state held before that edge's update. Without a lookup, all `pred_*` outputs are 0.
- R2: The set index is `addr[5:0]` and the tag is `addr[31:6]`. `pred_hit=1` only when a valid way in that set holds the same tag.
- R3: On a miss in all ways, `pred_hit`, `pred_taken` and `pred_is_ret` are 0 and `pred_target` is 0, which means fall through.
- R4: On a hit to a non-return entry, `pred_taken` equals the counter's upper bit (counter values 2 and 3 predict taken). `pred_target` is the stored target when taken and 0 otherwise.
- R5: An update that hits moves the counter up on taken and down on not-taken, saturating at 0 and 3. It also rewrites the target and the return flag with the update's values.
- R6: An update that misses and was taken writes a new entry with counter value 2 into the victim way. An update that misses and was not taken changes nothing.
- R7: The victim is chosen by a per-set three-bit pseudo-LRU tree. Ways are numbered 0 to 3. The root bit chooses the pair (0 picks ways 0-1). The bit of that pair chooses the way inside it (0 picks the lower way). Every hit-update or allocation sets both bits on its path to point away from the way it touched.
- R8: `upd_call` pushes `upd_next` onto an eight-entry return stack. `upd_ret` pops one entry, and a pop on an empty stack does nothing. A ninth push overwrites the oldest entry, and the depth stays at eight.
- R9: A hit to a return entry sets `pred_is_ret=1`. `pred_taken` is 1 with the stack top as target when the stack is non-empty. When the stack is empty, `pred_taken` and `pred_target` are 0.
- R10: `flush` invalidates every buffer entry, empties the stack and resets the pseudo-LRU state in one cycle. An update arriving in the same cycle is dropped, and a lookup arriving in the same cycle produces no `pred_valid`.
- R11: After reset the buffer and stack are empty and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear all prediction state |
| lk_valid | input | 1 | Lookup beat valid |
| lk_addr | input | 32 | Fetch address to look up |
| upd_valid | input | 1 | Resolution update valid |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Actual target |
| upd_taken | input | 1 | Branch was taken |
| upd_call | input | 1 | Branch was a call |
| upd_ret | input | 1 | Branch was a return |
| upd_next | input | 32 | Return address pushed by a call |
| pred_valid | output | 1 | Prediction beat valid |
| pred_hit | output | 1 | Buffer hit |
| pred_taken | output | 1 | Predicted taken |
| pred_is_ret | output | 1 | Hit entry is a return |
| pred_target | output | 32 | Predicted target (0 when not taken) |

## Verification
The assertions assume that resolution never marks one update as both a call and a return. The stimulus keeps to this by choosing at most one of the two flags on every generated update. They also assume that the pipeline consumes each prediction beat in the cycle it appears, since the block has no stall input. The bench drives inputs one cycle at a time, away from the clock edge. It mixes overlapping lookups, updates and flushes on a small pool of tags and sets, so that set conflicts, counter saturation and stack overflow and underflow all happen.

// File: rtl/fp_pkg.sv
package fp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_TAKEN = 2'd2;

  function automatic ctr_t ctr_step(ctr_t c, logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    else    return (c == 2'd0) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/fp_plru.sv
module fp_plru #(
  parameter int SETS = 64,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SET_W-1:0] set_sel,
  output logic [WAY_W-1:0] victim,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way
);
  // heap-ordered tree: node 1 is the root, bit 0 unused
  logic [WAYS-1:0] tree_q [SETS];
  logic [WAYS-1:0] tree_nxt;

  always_comb begin
    logic [WAY_W:0] nd;
    nd = 1;
    for (int l = 0; l < WAY_W; l++) nd = {nd[WAY_W-1:0], tree_q[set_sel][nd[WAY_W-1:0]]};
    victim = nd[WAY_W-1:0];
  end

  always_comb begin
    logic [WAY_W:0] nd;
    tree_nxt = tree_q[set_sel];
    nd = 1;
    for (int l = 0; l < WAY_W; l++) begin
      tree_nxt[nd[WAY_W-1:0]] = ~touch_way[WAY_W-1-l];
      nd = {nd[WAY_W-1:0], touch_way[WAY_W-1-l]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_en) begin
      tree_q[set_sel] <= tree_nxt;
    end
  end
endmodule

// File: rtl/fp_target_buf.sv
module fp_target_buf
  import fp_pkg::*;
#(
  parameter int AW   = 32,
  parameter int SETS = 64,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = AW - SET_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output ctr_t          lk_ctr,
  output logic [AW-1:0] lk_target,
  output logic          lk_ret,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_addr,
  input  logic [AW-1:0] upd_target,
  input  logic          upd_taken,
  input  logic          upd_ret
);
  logic [WAYS-1:0]  vld_q  [SETS];
  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [AW-1:0]    tgt_q  [SETS][WAYS];
  ctr_t             ctr_q  [SETS][WAYS];
  logic             ret_q  [SETS][WAYS];

  logic [SET_W-1:0] lk_set, up_set;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic [WAYS-1:0]  lk_match, up_match;
  logic [WAY_W-1:0] lk_way, up_way, victim, wr_way;
  logic             up_hit, wr_en;

  assign lk_set = lk_addr[SET_W-1:0];
  assign lk_tag = lk_addr[AW-1:SET_W];
  assign up_set = upd_addr[SET_W-1:0];
  assign up_tag = upd_addr[AW-1:SET_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    assign up_match[w] = vld_q[up_set][w] && (tag_q[up_set][w] == up_tag);
  end

  always_comb begin
    lk_way = '0;
    up_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lk_match[w]) lk_way = WAY_W'(w);
      if (up_match[w]) up_way = WAY_W'(w);
    end
  end

  assign lk_hit    = |lk_match;
  assign lk_ctr    = ctr_q[lk_set][lk_way];
  assign lk_target = tgt_q[lk_set][lk_way];
  assign lk_ret    = ret_q[lk_set][lk_way];

  assign up_hit = |up_match;
  assign wr_en  = upd_en && !flush && (up_hit || upd_taken);
  assign wr_way = up_hit ? up_way : victim;

  fp_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (flush),
    .set_sel   (up_set),
    .victim    (victim),
    .touch_en  (wr_en),
    .touch_way (wr_way)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[up_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[up_set][wr_way] <= up_tag;
      tgt_q[up_set][wr_way] <= upd_target;
      ret_q[up_set][wr_way] <= upd_ret;
      ctr_q[up_set][wr_way] <= up_hit ? ctr_step(ctr_q[up_set][wr_way], upd_taken)
                                      : CTR_WEAK_TAKEN;
    end
  end
endmodule

// File: rtl/fp_ret_stack.sv
module fp_ret_stack #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [AW-1:0]    push_val,
  input  logic             pop,
  output logic [AW-1:0]    top,
  output logic             top_ok,
  output logic [CNT_W-1:0] depth
);
  logic [AW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] sp;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sp  <= '0;
      cnt <= '0;
    end else if (push) begin
      sp <= sp + 1'b1;
      if (cnt != CNT_W'(DEPTH)) cnt <= cnt + 1'b1;
    end else if (pop && cnt != '0) begin
      sp  <= sp - 1'b1;
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[sp] <= push_val;
  end

  assign top    = mem[sp - 1'b1];
  assign top_ok = (cnt != '0);
  assign depth  = cnt;
endmodule

// File: rtl/fetch_predictor.sv
module fetch_predictor
  import fp_pkg::*;
#(
  parameter int AW        = 32,
  parameter int SETS      = 64,
  parameter int WAYS      = 4,
  parameter int RAS_DEPTH = 8,
  localparam int CNT_W    = $clog2(RAS_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  input  logic          upd_valid,
  input  logic [AW-1:0] upd_addr,
  input  logic [AW-1:0] upd_target,
  input  logic          upd_taken,
  input  logic          upd_call,
  input  logic          upd_ret,
  input  logic [AW-1:0] upd_next,
  output logic          pred_valid,
  output logic          pred_hit,
  output logic          pred_taken,
  output logic          pred_is_ret,
  output logic [AW-1:0] pred_target
);
  logic          b_hit, b_ret, ras_ok;
  ctr_t          b_ctr;
  logic [AW-1:0] b_tgt, ras_top;
  logic [CNT_W-1:0] ras_cnt;

  fp_target_buf #(.AW(AW), .SETS(SETS), .WAYS(WAYS)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .lk_addr    (lk_addr),
    .lk_hit     (b_hit),
    .lk_ctr     (b_ctr),
    .lk_target  (b_tgt),
    .lk_ret     (b_ret),
    .upd_en     (upd_valid),
    .upd_addr   (upd_addr),
    .upd_target (upd_target),
    .upd_taken  (upd_taken),
    .upd_ret    (upd_ret)
  );

  fp_ret_stack #(.AW(AW), .DEPTH(RAS_DEPTH)) u_ras (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (flush),
    .push     (upd_valid && upd_call && !flush),
    .push_val (upd_next),
    .pop      (upd_valid && upd_ret && !flush),
    .top      (ras_top),
    .top_ok   (ras_ok),
    .depth    (ras_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || flush || !lk_valid) begin
      pred_valid  <= 1'b0;
      pred_hit    <= 1'b0;
      pred_taken  <= 1'b0;
      pred_is_ret <= 1'b0;
      pred_target <= '0;
    end else begin
      pred_valid  <= 1'b1;
      pred_hit    <= b_hit;
      pred_is_ret <= b_hit && b_ret;
      if (!b_hit) begin
        pred_taken  <= 1'b0;
        pred_target <= '0;
      end else if (b_ret) begin
        pred_taken  <= ras_ok;
        pred_target <= ras_ok ? ras_top : '0;
      end else begin
        pred_taken  <= b_ctr[1];
        pred_target <= b_ctr[1] ? b_tgt : '0;
      end
    end
  end
endmodule

// File: rtl/fp_chk.sv
module fp_chk #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             lk_valid,
  input logic             upd_valid,
  input logic             upd_call,
  input logic             upd_ret,
  input logic             pred_valid,
  input logic             pred_hit,
  input logic             pred_taken,
  input logic             pred_is_ret,
  input logic [AW-1:0]    pred_target,
  input logic [CNT_W-1:0] ras_cnt
);
  // R1
  beat_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> ($past(lk_valid) && !$past(flush)));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid |-> (!pred_hit && !pred_taken && pred_target == '0));
  // R3
  miss_fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_hit |-> (!pred_taken && !pred_is_ret && pred_target == '0));
  // R8
  ras_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ras_cnt <= CNT_W'(DEPTH));
  // R8
  ras_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_call && !flush && ras_cnt != CNT_W'(DEPTH))
      |=> ras_cnt == $past(ras_cnt) + 1'b1);
  // R9
  ret_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_is_ret |-> (pred_taken == ($past(ras_cnt) != '0)));
  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!pred_valid && ras_cnt == '0));
  // R8
  call_ret_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && upd_call && upd_ret));
endmodule

bind fetch_predictor fp_chk #(.AW(AW), .DEPTH(RAS_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .lk_valid    (lk_valid),
  .upd_valid   (upd_valid),
  .upd_call    (upd_call),
  .upd_ret     (upd_ret),
  .pred_valid  (pred_valid),
  .pred_hit    (pred_hit),
  .pred_taken  (pred_taken),
  .pred_is_ret (pred_is_ret),
  .pred_target (pred_target),
  .ras_cnt     (ras_cnt)
);

// File: tb/sim_fetch_predictor.sv
module sim_fetch_predictor;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, flush, lk_valid, upd_valid, upd_taken, upd_call, upd_ret;
  logic [31:0] lk_addr, upd_addr, upd_target, upd_next;
  logic        pred_valid, pred_hit, pred_taken, pred_is_ret;
  logic [31:0] pred_target;

  fetch_predictor u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_target(upd_target),
    .upd_taken(upd_taken), .upd_call(upd_call), .upd_ret(upd_ret), .upd_next(upd_next),
    .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_taken(pred_taken),
    .pred_is_ret(pred_is_ret), .pred_target(pred_target)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R11";

  // behavioural reference
  bit          m_vld [64][4];
  int unsigned m_tag [64][4];
  int unsigned m_tgt [64][4];
  int          m_ctr [64][4];
  bit          m_ret [64][4];
  bit [2:0]    m_pl  [64];
  int unsigned m_stk [8];
  int          m_sp, m_cnt;

  function automatic int find_way(int unsigned a);
    for (int w = 0; w < 4; w++)
      if (m_vld[a % 64][w] && m_tag[a % 64][w] == a / 64) return w;
    return -1;
  endfunction

  function automatic void touch(int s, int w);
    m_pl[s][0] = (w < 2);
    if (w < 2) m_pl[s][1] = (w == 0);
    else       m_pl[s][2] = (w == 2);
  endfunction

  function automatic void model_clear();
    for (int s = 0; s < 64; s++) begin
      m_pl[s] = 3'b000;
      for (int w = 0; w < 4; w++) m_vld[s][w] = 0;
    end
    m_sp = 0;
    m_cnt = 0;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) %s act=%0h exp=%0h at %0t", req, phase, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    flush = 0; lk_valid = 0; lk_addr = 0; upd_valid = 0; upd_addr = 0;
    upd_target = 0; upd_taken = 0; upd_call = 0; upd_ret = 0; upd_next = 0;
  endtask

  task automatic tick();
    bit e_v, e_h, e_t, e_r;
    int unsigned e_tg;
    int w, s;
    string rq;
    e_v = lk_valid && !flush;
    e_h = 0; e_t = 0; e_r = 0; e_tg = 0;
    if (e_v) begin
      w = find_way(lk_addr);
      s = int'(lk_addr % 64);
      if (w >= 0) begin
        e_h = 1;
        if (m_ret[s][w]) begin
          e_r = 1;
          e_t = (m_cnt > 0);
          e_tg = e_t ? m_stk[(m_sp + 7) % 8] : 0;
        end else begin
          e_t = (m_ctr[s][w] >= 2);
          e_tg = e_t ? m_tgt[s][w] : 0;
        end
      end
    end
    @(posedge clk);
    #1;
    rq = e_r ? "R9" : (e_h ? "R4" : "R3");
    chk(pred_valid == e_v, "R1", "pred_valid", pred_valid, e_v);
    chk(pred_hit == e_h, "R2", "pred_hit", pred_hit, e_h);
    chk(pred_is_ret == e_r, "R9", "pred_is_ret", pred_is_ret, e_r);
    chk(pred_taken == e_t, rq, "pred_taken", pred_taken, e_t);
    chk(pred_target == e_tg, rq, "pred_target", pred_target, e_tg);
    // reference update (R5 R6 R7 R8 R10)
    if (flush) model_clear();
    else if (upd_valid) begin
      s = int'(upd_addr % 64);
      w = find_way(upd_addr);
      if (w >= 0) begin
        if (upd_taken) m_ctr[s][w] = (m_ctr[s][w] < 3) ? m_ctr[s][w] + 1 : 3;
        else           m_ctr[s][w] = (m_ctr[s][w] > 0) ? m_ctr[s][w] - 1 : 0;
        m_tgt[s][w] = upd_target;
        m_ret[s][w] = upd_ret;
        touch(s, w);
      end else if (upd_taken) begin
        w = m_pl[s][0] ? (m_pl[s][2] ? 3 : 2) : (m_pl[s][1] ? 1 : 0);
        m_vld[s][w] = 1; m_tag[s][w] = upd_addr / 64; m_tgt[s][w] = upd_target;
        m_ctr[s][w] = 2; m_ret[s][w] = upd_ret;
        touch(s, w);
      end
      if (upd_call) begin
        m_stk[m_sp] = upd_next;
        m_sp = (m_sp + 1) % 8;
        if (m_cnt < 8) m_cnt++;
      end else if (upd_ret && m_cnt > 0) begin
        m_sp = (m_sp + 7) % 8;
        m_cnt--;
      end
    end
    idle();
  endtask

  task automatic look(int unsigned a);
    lk_valid = 1; lk_addr = a; tick();
  endtask

  task automatic upd(int unsigned a, int unsigned t, bit tk, bit c, bit r, int unsigned nx);
    upd_valid = 1; upd_addr = a; upd_target = t; upd_taken = tk;
    upd_call = c; upd_ret = r; upd_next = nx; tick();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    model_clear();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R11: outputs idle after reset
    chk(pred_valid == 0 && pred_hit == 0 && pred_taken == 0, "R11", "reset outputs",
        {pred_valid, pred_hit, pred_taken}, 0);
    chk(pred_target == 0, "R11", "reset target", pred_target, 0);
    look(32'h0000_1000);

    phase = "R3"; look(32'h0000_2345);
    phase = "R6";
    upd(32'h0000_1000, 32'h0000_8000, 1, 0, 0, 0);
    upd(32'h0000_3005, 32'h0000_9000, 0, 0, 0, 0);
    look(32'h0000_3005);
    phase = "R4"; look(32'h0000_1000);
    phase = "R5";
    for (int i = 0; i < 3; i++) begin upd(32'h0000_1000, 32'h0000_8000, 0, 0, 0, 0); look(32'h0000_1000); end
    for (int i = 0; i < 4; i++) begin upd(32'h0000_1000, 32'h0000_8800, 1, 0, 0, 0); look(32'h0000_1000); end
    phase = "R2"; look(32'h0000_1040); look(32'h0000_1001); look(32'h0001_1000);
    phase = "R7";
    for (int i = 0; i < 6; i++) upd(32'h0000_0007 + 32'(i) * 64, 32'h0000_A000 + 32'(i), 1, 0, 0, 0);
    upd(32'h0000_0047, 32'h0000_B000, 1, 0, 0, 0);
    upd(32'h0000_0207, 32'h0000_C000, 1, 0, 0, 0);
    for (int i = 0; i < 9; i++) look(32'h0000_0007 + 32'(i) * 64);
    phase = "R1";
    lk_valid = 1; lk_addr = 32'h0000_5011;
    upd_valid = 1; upd_addr = 32'h0000_5011; upd_target = 32'h0000_6000; upd_taken = 1;
    tick();
    look(32'h0000_5011);
    phase = "R9";
    upd(32'h0000_4400, 32'h0, 1, 0, 1, 0);
    look(32'h0000_4400);
    phase = "R8";
    for (int i = 0; i < 10; i++) upd(32'h0000_7000, 32'h0000_7100, 1, 1, 0, 32'h0000_9000 + 32'(i));
    for (int i = 0; i < 10; i++) begin look(32'h0000_4400); upd(32'h0000_4400, 32'h0, 1, 0, 1, 0); end
    look(32'h0000_4400);
    phase = "R10";
    upd(32'h0000_7000, 32'h0000_7100, 1, 1, 0, 32'h0000_9999);
    flush = 1; lk_valid = 1; lk_addr = 32'h0000_1000;
    upd_valid = 1; upd_addr = 32'h0000_0F00; upd_target = 32'h1; upd_taken = 1; upd_call = 1;
    tick();
    look(32'h0000_1000); look(32'h0000_0F00); look(32'h0000_7000);
    upd(32'h0000_4400, 32'h0, 1, 0, 1, 0); look(32'h0000_4400);

    phase = "mixed";
    for (int n = 0; n < 4000; n++) begin
      int unsigned a, b;
      int k;
      a = ($urandom % 6) * 64 + (($urandom % 4) == 0 ? 63 : $urandom % 3);
      b = ($urandom % 6) * 64 + (($urandom % 4) == 0 ? 63 : $urandom % 3);
      lk_valid = ($urandom % 3) != 0; lk_addr = a;
      if (($urandom % 2) == 0) begin
        k = int'($urandom % 8);
        upd_valid = 1; upd_addr = b; upd_target = $urandom; upd_taken = ($urandom % 3) != 0;
        upd_call = (k == 0); upd_ret = (k == 1); upd_next = $urandom;
      end
      flush = ($urandom % 300) == 0;
      tick();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule